// File: doc/BRIEF.md
# Triggered CPU Bus Trace Capture

This block watches the bus of an 8-bit microprocessor and writes one record per bus cycle into an on-chip trace memory. Each record holds the 16-bit address, the 8-bit data and the read/write strobe, taken when the phase-2 clock falls. The record is written at the address given by the low bits of a free-running bus-cycle counter. The top bit of that counter is also brought out as a coarse rate tap: it falls once per full counter period, and a host can time those falls to estimate the effective CPU clock rate.

A host arms the block and selects a capture mode and a trigger source. The trigger is either the assertion of the CPU reset line or a rising edge on a general-purpose pin driven by an I/O peripheral. In window mode the block waits for the trigger, then fills the memory exactly once. In history mode it records circularly from the moment it is armed and stops when the trigger arrives, so the memory holds the cycles that led up to the event. The host then reads samples by logical index, where index 0 is always the oldest stored sample.

Top module: `bus_trace_capture`

## Requirements
- R1: After reset the state reads 0 (idle), the wrapped flag is 0, rd_valid is 0 and the rate tap is 0.
- R2: On each falling edge of bus_phi2, the values on bus_addr, bus_data and bus_rw are stored together as one sample. When read back they appear unchanged on rd_addr, rd_data and rd_rw.
- R3: A CNT_W-bit counter (16 by default) counts every bus cycle from reset, whatever the state. freq_tap equals its top bit, so it falls once every 2^CNT_W bus cycles.
- R4: Window mode (host_cont=0). An arm pulse moves the state to 1 (armed). A trigger moves it to 2 (capturing). Exactly 2^IDX_W consecutive cycles are then stored, and the state becomes 3 (done). Read index 0 returns the first stored cycle.
- R5: History mode (host_cont=1). An arm pulse moves the state straight to 2 and samples are written circularly. A trigger moves the state to 3 and stops writing. The newest stored sample is the last bus cycle at or before the trigger.
- R6: st_wrapped is 1 once at least 2^IDX_W samples have been stored since the last arm. st_stop_ptr gives the memory slot of the newest sample. Read index i returns the i-th oldest sample: it starts at st_stop_ptr+1 when wrapped, and at the first written slot otherwise.
- R7: host_src, latched at arm, picks the trigger source. With host_src=0 the trigger is a falling edge of cpu_resb (the reset is active low). With host_src=1 it is a rising edge of gpio_trig. A level held over many cycles gives one trigger only, and the source that is not selected has no effect.
- R8: A trigger has no effect in state 0 or state 3. An arm pulse restarts capture from any state.
- R9: rd_req with rd_idx gives rd_valid and the sample one clock later. If a sample write falls in the request cycle, the read is held and served in the next clock without a write.
- R10: When the trigger and a bus-cycle strobe fall in the same clock, that cycle's sample is stored in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus |
| rst_n | input | 1 | Active-low block reset |
| bus_phi2 | input | 1 | CPU phase-2 clock, sampled asynchronously |
| bus_addr | input | 16 | CPU address bus |
| bus_data | input | 8 | CPU data bus |
| bus_rw | input | 1 | CPU read/write strobe |
| cpu_resb | input | 1 | CPU reset line, active low, usable as trigger |
| gpio_trig | input | 1 | Peripheral output pin, usable as trigger |
| host_arm | input | 1 | One-clock pulse that starts a capture |
| host_cont | input | 1 | Mode at arm: 0 window, 1 history |
| host_src | input | 1 | Trigger source at arm: 0 reset line, 1 pin |
| rd_req | input | 1 | One-clock read request |
| rd_idx | input | IDX_W | Logical sample index, 0 = oldest |
| rd_valid | output | 1 | Read result valid |
| rd_addr | output | 16 | Address field of the read sample |
| rd_data | output | 8 | Data field of the read sample |
| rd_rw | output | 1 | Read/write field of the read sample |
| st_state | output | 2 | 0 idle, 1 armed, 2 capturing, 3 done |
| st_wrapped | output | 1 | Memory filled at least once since arm |
| st_stop_ptr | output | IDX_W | Slot of the newest stored sample |
| freq_tap | output | 1 | Top bit of the bus-cycle counter |

## Verification
The trigger event and the bus-cycle strobe can land in the same clock, and both then act on one sample write. The bench provokes this by driving the trigger edge at the same instant that bus_phi2 falls. Because the two synchronisers have equal depth, the two events reach the control logic together. The result is judged by readback: in window mode index 0 must be that cycle's sample, and in history mode it must be the newest stored sample. A second collision, between a host read and a sample write, is forced by timing rd_req onto the write clock. It is judged by rd_valid staying low for one clock and then rising.

// File: rtl/trc_pkg.sv
`timescale 1ns/1ps
package trc_pkg;
    localparam int unsigned BUS_AW = 16;
    localparam int unsigned BUS_DW = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_CAPT  = 2'd2,
        ST_DONE  = 2'd3
    } trc_state_e;

    typedef struct packed {
        logic [BUS_AW-1:0] addr;
        logic [BUS_DW-1:0] data;
        logic              rw;
    } trc_sample_t;

    localparam int unsigned SAMPLE_W = $bits(trc_sample_t);
endpackage

// File: rtl/trc_sync_edge.sv
`timescale 1ns/1ps
module trc_sync_edge #(
    parameter int unsigned STAGES  = 2,
    parameter bit          RISE    = 1'b1,
    parameter bit          RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic edge_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_s;

    sync_s sy_q, sy_d;

    always_comb begin
        sy_d       = sy_q;
        sy_d.chain = {sy_q.chain[STAGES-2:0], async_i};
        sy_d.prev  = sy_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy_q.chain <= {STAGES{RST_VAL}};
            sy_q.prev  <= RST_VAL;
        end else begin
            sy_q <= sy_d;
        end
    end

    generate
        if (RISE) begin : g_rise
            assign edge_o = sy_q.chain[STAGES-1] & ~sy_q.prev;
        end else begin : g_fall
            assign edge_o = ~sy_q.chain[STAGES-1] & sy_q.prev;
        end
    endgenerate

    // R7: a held level yields a single one-clock event
    p_one_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o)
        else $error("p_one_event_r7");
endmodule

// File: rtl/trc_ram.sv
`timescale 1ns/1ps
module trc_ram #(
    parameter int unsigned AW = 10,
    parameter int unsigned DW = 25
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem_q[addr] <= wdata;
            else    rdata_q     <= mem_q[addr];
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/trc_ctrl.sv
`timescale 1ns/1ps
module trc_ctrl import trc_pkg::*; #(
    parameter int unsigned IDX_W = 10,
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe_i,
    input  logic             ev_rst_i,
    input  logic             ev_gpio_i,
    input  logic             arm_i,
    input  logic             cont_i,
    input  logic             src_gpio_i,
    output trc_state_e       state_o,
    output logic             wr_en_o,
    output logic [IDX_W-1:0] wr_ptr_o,
    output logic             tap_o,
    output logic             wrapped_o,
    output logic [IDX_W-1:0] start_o,
    output logic [IDX_W-1:0] stop_o
);
    localparam int unsigned DEPTH   = 1 << IDX_W;
    localparam logic [IDX_W:0] FULL    = (IDX_W+1)'(DEPTH);
    localparam logic [IDX_W:0] FULL_M1 = (IDX_W+1)'(DEPTH - 1);

    typedef struct packed {
        trc_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic [IDX_W:0]   wcnt;
        logic [IDX_W-1:0] start;
        logic [IDX_W-1:0] stop;
        logic             cont;
        logic             src;
    } ctrl_s;

    ctrl_s ct_q, ct_d;
    logic  trig;
    logic  wr;

    always_comb begin
        ct_d = ct_q;
        trig = ct_q.src ? ev_gpio_i : ev_rst_i;
        wr   = strobe_i && !arm_i &&
               ((ct_q.state == ST_CAPT) || (ct_q.state == ST_ARMED && trig));

        if (strobe_i) ct_d.cnt = ct_q.cnt + CNT_W'(1);

        if (arm_i) begin
            if (cont_i) ct_d.state = ST_CAPT;
            else        ct_d.state = ST_ARMED;
            ct_d.wcnt = '0;
            ct_d.cont = cont_i;
            ct_d.src  = src_gpio_i;
        end else begin
            if (wr) begin
                if (ct_q.wcnt == '0) ct_d.start = ct_q.cnt[IDX_W-1:0];
                ct_d.stop = ct_q.cnt[IDX_W-1:0];
                if (ct_q.wcnt != FULL) ct_d.wcnt = ct_q.wcnt + (IDX_W+1)'(1);
            end
            case (ct_q.state)
                ST_ARMED: if (trig) ct_d.state = ST_CAPT;
                ST_CAPT: begin
                    if (ct_q.cont) begin
                        if (trig) ct_d.state = ST_DONE;
                    end else if (wr && ct_q.wcnt == FULL_M1) begin
                        ct_d.state = ST_DONE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ct_q <= '0;
        else        ct_q <= ct_d;
    end

    assign state_o   = ct_q.state;
    assign wr_en_o   = wr;
    assign wr_ptr_o  = ct_q.cnt[IDX_W-1:0];
    assign tap_o     = ct_q.cnt[CNT_W-1];
    assign wrapped_o = (ct_q.wcnt == FULL);
    assign start_o   = ct_q.start;
    assign stop_o    = ct_q.stop;

    // R8: no trigger leaves idle or done; only an arm does
    p_idle_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ct_q.state == ST_IDLE && !arm_i) |=> ct_q.state == ST_IDLE)
        else $error("p_idle_holds_r8");
    p_done_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ct_q.state == ST_DONE && !arm_i) |=> ct_q.state == ST_DONE)
        else $error("p_done_holds_r8");
    // R3: each bus cycle advances the counter by one
    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_i |=> ct_q.cnt == CNT_W'($past(ct_q.cnt) + CNT_W'(1)))
        else $error("p_count_step_r3");
    // R4: the stored count never exceeds the memory depth
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ct_q.wcnt <= FULL)
        else $error("p_no_overflow_r4");
    // R4: window mode finishes only with a full memory
    p_window_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ct_q.state == ST_DONE && !ct_q.cont) |-> ct_q.wcnt == FULL)
        else $error("p_window_full_r4");
    // R5: writes happen only while armed-and-triggered or capturing
    p_write_states_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr |-> (ct_q.state == ST_CAPT || ct_q.state == ST_ARMED))
        else $error("p_write_states_r5");
endmodule

// File: rtl/bus_trace_capture.sv
`timescale 1ns/1ps
module bus_trace_capture import trc_pkg::*; #(
    parameter int unsigned IDX_W       = 10,
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_phi2,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_data,
    input  logic              bus_rw,
    input  logic              cpu_resb,
    input  logic              gpio_trig,
    input  logic              host_arm,
    input  logic              host_cont,
    input  logic              host_src,
    input  logic              rd_req,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [BUS_AW-1:0] rd_addr,
    output logic [BUS_DW-1:0] rd_data,
    output logic              rd_rw,
    output logic [1:0]        st_state,
    output logic              st_wrapped,
    output logic [IDX_W-1:0]  st_stop_ptr,
    output logic              freq_tap
);
    logic             strobe, ev_rst, ev_gpio;
    trc_state_e       state;
    logic             wr_en;
    logic [IDX_W-1:0] wr_ptr, start_ptr, stop_ptr, base, phys, sel_idx;
    logic             wrapped;
    logic             rd_go;
    trc_sample_t      wsample, rsample;
    logic [IDX_W-1:0] ram_addr;

    trc_sync_edge #(.STAGES(SYNC_STAGES), .RISE(1'b0), .RST_VAL(1'b0)) u_phi2 (
        .clk(clk), .rst_n(rst_n), .async_i(bus_phi2), .edge_o(strobe));
    trc_sync_edge #(.STAGES(SYNC_STAGES), .RISE(1'b0), .RST_VAL(1'b1)) u_resb (
        .clk(clk), .rst_n(rst_n), .async_i(cpu_resb), .edge_o(ev_rst));
    trc_sync_edge #(.STAGES(SYNC_STAGES), .RISE(1'b1), .RST_VAL(1'b0)) u_gpio (
        .clk(clk), .rst_n(rst_n), .async_i(gpio_trig), .edge_o(ev_gpio));

    trc_ctrl #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .strobe_i(strobe), .ev_rst_i(ev_rst),
        .ev_gpio_i(ev_gpio), .arm_i(host_arm), .cont_i(host_cont),
        .src_gpio_i(host_src), .state_o(state), .wr_en_o(wr_en),
        .wr_ptr_o(wr_ptr), .tap_o(freq_tap), .wrapped_o(wrapped),
        .start_o(start_ptr), .stop_o(stop_ptr));

    typedef struct packed {
        logic             pend;
        logic [IDX_W-1:0] idx;
        logic             valid;
    } rdp_s;

    rdp_s rp_q, rp_d;

    always_comb begin
        rp_d    = rp_q;
        rd_go   = (rd_req | rp_q.pend) & ~wr_en;
        sel_idx = rd_req ? rd_idx : rp_q.idx;
        base    = wrapped ? stop_ptr + IDX_W'(1) : start_ptr;
        phys    = base + sel_idx;
        if (rd_req && wr_en) begin
            rp_d.pend = 1'b1;
            rp_d.idx  = rd_idx;
        end else if (rd_go) begin
            rp_d.pend = 1'b0;
        end
        rp_d.valid = rd_go;
        ram_addr   = wr_en ? wr_ptr : phys;
        wsample.addr = bus_addr;
        wsample.data = bus_data;
        wsample.rw   = bus_rw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rp_q <= '0;
        else        rp_q <= rp_d;
    end

    trc_ram #(.AW(IDX_W), .DW(SAMPLE_W)) u_ram (
        .clk(clk), .en(wr_en | rd_go), .we(wr_en), .addr(ram_addr),
        .wdata(wsample), .rdata(rsample));

    assign rd_valid    = rp_q.valid;
    assign rd_addr     = rsample.addr;
    assign rd_data     = rsample.data;
    assign rd_rw       = rsample.rw;
    assign st_state    = state;
    assign st_wrapped  = wrapped;
    assign st_stop_ptr = stop_ptr;

    // R9: a request that meets no write is answered next clock
    p_read_answer_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !wr_en) |=> rd_valid)
        else $error("p_read_answer_r9");
endmodule

// File: tb/bus_trace_capture_bench.sv
`timescale 1ns/1ps
module bus_trace_capture_bench;
    localparam int IW = 4;
    localparam int CW = 8;
    localparam int D  = 1 << IW;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0;
    logic bus_phi2 = 1'b0, bus_rw = 1'b0, cpu_resb = 1'b1, gpio_trig = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_data = '0;
    logic host_arm = 1'b0, host_cont = 1'b0, host_src = 1'b1, rd_req = 1'b0;
    logic [IW-1:0] rd_idx = '0;
    logic rd_valid, rd_rw, st_wrapped, freq_tap;
    logic [15:0] rd_addr;
    logic [7:0]  rd_data;
    logic [1:0]  st_state;
    logic [IW-1:0] st_stop_ptr;

    bus_trace_capture #(.IDX_W(IW), .CNT_W(CW)) u_bus_trace_capture (
        .clk(clk), .rst_n(rst_n), .bus_phi2(bus_phi2), .bus_addr(bus_addr),
        .bus_data(bus_data), .bus_rw(bus_rw), .cpu_resb(cpu_resb),
        .gpio_trig(gpio_trig), .host_arm(host_arm), .host_cont(host_cont),
        .host_src(host_src), .rd_req(rd_req), .rd_idx(rd_idx),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data),
        .rd_rw(rd_rw), .st_state(st_state), .st_wrapped(st_wrapped),
        .st_stop_ptr(st_stop_ptr), .freq_tap(freq_tap));

    int errors = 0;
    int checks = 0;
    int ncyc   = 0;
    bit use_gpio = 1'b1;

    function automatic logic [15:0] s_addr(int n);
        return 16'((n * 313) ^ 16'h5A3C);
    endfunction
    function automatic logic [7:0] s_data(int n);
        return 8'(n * 29 + 7);
    endfunction
    function automatic logic s_rw(int n);
        return 1'(n) ^ 1'(n >> 2);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_cycle(input bit fire, input bit rdc);
        @(negedge clk);
        bus_phi2 = 1'b1;
        bus_addr = s_addr(ncyc);
        bus_data = s_data(ncyc);
        bus_rw   = s_rw(ncyc);
        @(negedge clk);
        @(negedge clk);
        bus_phi2 = 1'b0;
        if (fire) begin
            if (use_gpio) gpio_trig = 1'b1;
            else          cpu_resb  = 1'b0;
        end
        @(negedge clk);
        @(negedge clk);
        if (rdc) begin rd_req = 1'b1; rd_idx = '0; end
        @(negedge clk);
        if (rdc) begin
            rd_req = 1'b0;
            chk("R9 read held during write", {31'd0, rd_valid}, 32'd0);
        end
        @(negedge clk);
        if (rdc) chk("R9 held read served", {31'd0, rd_valid}, 32'd1);
        ncyc++;
    endtask

    task automatic arm(input bit cont, input bit src);
        @(negedge clk);
        host_arm = 1'b1; host_cont = cont; host_src = src;
        @(negedge clk);
        host_arm = 1'b0;
    endtask

    task automatic rd_check(input string tag, input int idx, input int n);
        @(negedge clk);
        rd_req = 1'b1; rd_idx = IW'(idx);
        @(negedge clk);
        rd_req = 1'b0;
        chk({tag, " valid"}, {31'd0, rd_valid}, 32'd1);
        chk({tag, " addr"}, {16'd0, rd_addr}, {16'd0, s_addr(n)});
        chk({tag, " data"}, {24'd0, rd_data}, {24'd0, s_data(n)});
        chk({tag, " rw"}, {31'd0, rd_rw}, {31'd0, s_rw(n)});
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        int k, a, k2, f0, falls, prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 state", {30'd0, st_state}, 32'd0);
        chk("R1 wrapped", {31'd0, st_wrapped}, 32'd0);
        chk("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
        chk("R1 tap", {31'd0, freq_tap}, 32'd0);

        // R8: triggers in idle are ignored
        use_gpio = 1'b1;
        bus_cycle(1'b1, 1'b0);
        gpio_trig = 1'b0; cpu_resb = 1'b0;
        bus_cycle(1'b0, 1'b0);
        cpu_resb = 1'b1;
        bus_cycle(1'b0, 1'b0);
        chk("R8 idle ignores trigger", {30'd0, st_state}, 32'd0);

        // R4 / R10: window mode, trigger coincides with a strobe
        arm(1'b0, 1'b1);
        chk("R4 armed", {30'd0, st_state}, 32'd1);
        repeat (3) bus_cycle(1'b0, 1'b0);
        chk("R4 waits for trigger", {30'd0, st_state}, 32'd1);
        k = ncyc;
        bus_cycle(1'b1, 1'b0);
        chk("R4 capturing", {30'd0, st_state}, 32'd2);
        repeat (D - 2) bus_cycle(1'b0, 1'b0);
        chk("R4 one short of full", {30'd0, st_state}, 32'd2);
        bus_cycle(1'b0, 1'b0);
        chk("R4 done after full window", {30'd0, st_state}, 32'd3);
        repeat (2) bus_cycle(1'b0, 1'b0);
        chk("R6 wrapped in window", {31'd0, st_wrapped}, 32'd1);
        chk("R6 stop pointer", {28'd0, st_stop_ptr}, 32'((k + D - 1) % D));
        for (int i = 0; i < D; i++) rd_check("R4 R10 R2 window sample", i, k + i);

        // R7: held level gives no new event; other source ignored
        arm(1'b0, 1'b1);
        repeat (3) bus_cycle(1'b0, 1'b0);
        chk("R7 held level no retrigger", {30'd0, st_state}, 32'd1);
        gpio_trig = 1'b0;
        bus_cycle(1'b0, 1'b0);
        cpu_resb = 1'b0;
        repeat (2) bus_cycle(1'b0, 1'b0);
        cpu_resb = 1'b1;
        bus_cycle(1'b0, 1'b0);
        chk("R7 unselected reset ignored", {30'd0, st_state}, 32'd1);

        // R4: trigger between bus cycles, first sample is the next cycle
        @(negedge clk);
        gpio_trig = 1'b1;
        repeat (4) @(negedge clk);
        chk("R4 trigger without strobe", {30'd0, st_state}, 32'd2);
        k2 = ncyc;
        repeat (D) bus_cycle(1'b0, 1'b0);
        chk("R4 done second window", {30'd0, st_state}, 32'd3);
        rd_check("R4 first after idle trigger", 0, k2);
        rd_check("R4 last of window", D - 1, k2 + D - 1);

        // R8: trigger in done is ignored
        gpio_trig = 1'b0;
        bus_cycle(1'b0, 1'b0);
        bus_cycle(1'b1, 1'b0);
        bus_cycle(1'b0, 1'b0);
        chk("R8 done ignores trigger", {30'd0, st_state}, 32'd3);
        chk("R8 stop pointer kept", {28'd0, st_stop_ptr}, 32'((k2 + D - 1) % D));
        rd_check("R8 content kept", 0, k2);
        gpio_trig = 1'b0;

        // R5 / R7 / R10: history mode on reset line, short run
        use_gpio = 1'b0;
        arm(1'b1, 1'b0);
        chk("R5 capturing at arm", {30'd0, st_state}, 32'd2);
        a = ncyc;
        repeat (5) bus_cycle(1'b0, 1'b0);
        k = ncyc;
        bus_cycle(1'b1, 1'b0);
        chk("R5 done on reset trigger", {30'd0, st_state}, 32'd3);
        cpu_resb = 1'b1;
        bus_cycle(1'b0, 1'b0);
        chk("R6 not wrapped", {31'd0, st_wrapped}, 32'd0);
        chk("R6 stop pointer short", {28'd0, st_stop_ptr}, 32'(k % D));
        for (int i = 0; i < 6; i++) rd_check("R5 R6 R10 short history", i, a + i);

        // R5 / R6 / R9: history mode with wrap and a read collision
        arm(1'b1, 1'b0);
        for (int i = 0; i < 39; i++) bus_cycle(1'b0, i == 20);
        k = ncyc;
        bus_cycle(1'b1, 1'b0);
        cpu_resb = 1'b1;
        bus_cycle(1'b0, 1'b0);
        chk("R5 done wrapped history", {30'd0, st_state}, 32'd3);
        chk("R6 wrapped history", {31'd0, st_wrapped}, 32'd1);
        chk("R6 stop pointer wrapped", {28'd0, st_stop_ptr}, 32'(k % D));
        for (int i = 0; i < D; i++) rd_check("R5 R6 wrapped history", i, k - (D - 1) + i);

        // R3: rate tap follows the bus-cycle count
        f0 = ncyc;
        falls = 0;
        prev = freq_tap;
        for (int i = 0; i < 600; i++) begin
            bus_cycle(1'b0, 1'b0);
            if (prev == 1 && freq_tap == 1'b0) falls++;
            chk("R3 tap bit", {31'd0, freq_tap}, 32'((ncyc >> (CW - 1)) & 1));
            prev = freq_tap;
        end
        chk("R3 tap falls", 32'(falls), 32'((ncyc >> CW) - (f0 >> CW)));
        finish_run();
    end
endmodule